// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block is a small, fully associative cache of address translations. Each entry maps a virtual page number to a physical frame number. It also carries the address-space identifier of the owning process and a read-only flag. A lookup is answered combinationally in the same cycle: the presented page number and identifier are compared against every stored entry in parallel. A matching, permitted access returns the frame number and the assembled physical address. A write that matches a read-only entry reports a protection fault instead.

When a lookup misses, some agent outside the block obtains the translation and installs it through the fill port. Installation takes one clock edge. The slot is chosen in this order:

- an entry already holding the same page and identifier;
- otherwise the lowest-numbered empty slot;
- otherwise the least recently used entry.

Recency is tracked as a full age ordering. Every successful hit and every fill refresh it. Two invalidation inputs are provided: one empties the whole cache, and the other drops only the entries of one identifier.

Top module: `asid_tlb`

## Requirements
- R1: When lkValid is high and a valid entry matches both lkVpn and lkAsid and the access is permitted, lkHit is 1 in the same cycle, lkPfn is the stored frame, and lkPaddr is {frame, lkOffset} (frame in the upper bits, offset in the low OFF_W bits).
- R2: An entry whose stored identifier differs from lkAsid never produces a hit or a fault, even when the page number matches.
- R3: Whenever lkHit is 0, lkPfn and lkPaddr are 0. With lkValid low, lkHit and lkFault are 0.
- R4: A write lookup (lkWrite=1) matching a read-only entry gives lkFault=1 and lkHit=0. Reads of read-only entries hit. Writes to writable entries hit. lkFault is never 1 for a read.
- R5: A fill installs its translation at the clock edge, and a lookup in the next cycle hits with the filled frame.
- R6: A fill whose page and identifier already match a valid entry overwrites that entry in place, so no other entry is lost.
- R7: When any entry is invalid and no entry matches, a fill uses the lowest-numbered invalid entry, and no valid entry is evicted.
- R8: When all entries are valid, a fill evicts the least recently used entry. Hits and fills mark their entry as most recently used.
- R9: flushAll invalidates every entry at one clock edge and takes priority over a simultaneous fill, which is dropped.
- R10: flushAsidValid invalidates only entries whose identifier equals flushAsid, leaves other entries usable, and takes priority over a simultaneous fill.
- R11: After reset no lookup hits or faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request present |
| lkVpn | input | VPN_W | Virtual page number to translate |
| lkAsid | input | ASID_W | Identifier of the running process |
| lkWrite | input | 1 | 1 = write access, 0 = read access |
| lkOffset | input | OFF_W | Page offset appended to the frame |
| lkHit | output | 1 | Permitted translation found |
| lkFault | output | 1 | Write to a read-only page |
| lkPfn | output | PFN_W | Frame number on a hit, else 0 |
| lkPaddr | output | PFN_W+OFF_W | Physical address on a hit, else 0 |
| fillValid | input | 1 | Install a translation this cycle |
| fillVpn | input | VPN_W | Page number to install |
| fillAsid | input | ASID_W | Identifier to install |
| fillPfn | input | PFN_W | Frame number to install |
| fillReadOnly | input | 1 | Installed page is read-only |
| flushAll | input | 1 | Invalidate every entry |
| flushAsidValid | input | 1 | Invalidate entries of one identifier |
| flushAsid | input | ASID_W | Identifier to invalidate |

## Verification
On every cycle the assertions check four things:

- hit and fault are never raised together;
- a fault only appears on a write;
- the number of valid entries never falls except under a flush, and flushAll empties the cache at the next edge;
- a fill is visible, with its frame, to a read lookup in the following cycle.

Victim choice can only be shown by the directed scenarios. These cover the empty slot taken ahead of the LRU entry, eviction of the oldest entry after a hit refreshed another, and in-place overwrite of a duplicate. Selective flushing by identifier and the priority of flushes over a fill in the same cycle are also covered only by the scenarios.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic clrAll;   // drop every entry
    logic clrAsid;  // drop entries of one identifier
    logic wrEn;     // install fill at wrIdx
    logic touchEn;  // make touchIdx most recent
  } tlbStrobe_t;
endpackage

// File: rtl/asid_tlb_store.sv
module asid_tlb_store
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tlbStrobe_t               strb,
  input  logic [IDX_W-1:0]         wrIdx,
  input  logic [IDX_W-1:0]         touchIdx,
  input  logic [IDX_W-1:0]         rdIdx,
  input  logic [VPN_W-1:0]         fillVpn,
  input  logic [ASID_W-1:0]        fillAsid,
  input  logic [PFN_W-1:0]         fillPfn,
  input  logic                     fillReadOnly,
  input  logic [ASID_W-1:0]        flushAsid,
  input  logic [VPN_W-1:0]         lkVpn,
  input  logic [ASID_W-1:0]        lkAsid,
  output logic [ENTRIES-1:0]       matchVec,
  output logic [ENTRIES-1:0]       fillMatchVec,
  output logic [ENTRIES-1:0]       validVec,
  output logic [ENTRIES-1:0]       roVec,
  output logic [ENTRIES*IDX_W-1:0] ageFlat,
  output logic [PFN_W-1:0]         rdPfn
);
  logic [VPN_W-1:0]  entVpn  [ENTRIES];
  logic [ASID_W-1:0] entAsid [ENTRIES];
  logic [PFN_W-1:0]  entPfn  [ENTRIES];
  logic [IDX_W-1:0]  entAge  [ENTRIES];
  logic [IDX_W-1:0]  touchAge;

  assign touchAge = entAge[touchIdx];
  assign rdPfn    = entPfn[rdIdx];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEnt
    assign matchVec[g]     = validVec[g] && entVpn[g] == lkVpn && entAsid[g] == lkAsid;
    assign fillMatchVec[g] = validVec[g] && entVpn[g] == fillVpn && entAsid[g] == fillAsid;
    assign ageFlat[g*IDX_W +: IDX_W] = entAge[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[g] <= 1'b0;
        roVec[g]    <= 1'b0;
        entVpn[g]   <= '0;
        entAsid[g]  <= '0;
        entPfn[g]   <= '0;
        entAge[g]   <= IDX_W'(g);
      end else begin
        if (strb.clrAll) begin
          validVec[g] <= 1'b0;
        end else if (strb.clrAsid && entAsid[g] == flushAsid) begin
          validVec[g] <= 1'b0;
        end else if (strb.wrEn && wrIdx == IDX_W'(g)) begin
          validVec[g] <= 1'b1;
          roVec[g]    <= fillReadOnly;
          entVpn[g]   <= fillVpn;
          entAsid[g]  <= fillAsid;
          entPfn[g]   <= fillPfn;
        end
        // Ages stay a permutation: the touched entry becomes 0,
        // younger entries age by one
        if (strb.touchEn) begin
          if (touchIdx == IDX_W'(g)) entAge[g] <= '0;
          else if (entAge[g] < touchAge) entAge[g] <= entAge[g] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/asid_tlb_ctrl.sv
module asid_tlb_ctrl
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                     lkValid,
  input  logic                     lkWrite,
  input  logic [ENTRIES-1:0]       matchVec,
  input  logic [ENTRIES-1:0]       fillMatchVec,
  input  logic [ENTRIES-1:0]       validVec,
  input  logic [ENTRIES-1:0]       roVec,
  input  logic [ENTRIES*IDX_W-1:0] ageFlat,
  input  logic                     fillValid,
  input  logic                     flushAll,
  input  logic                     flushAsidValid,
  output tlbStrobe_t               strb,
  output logic [IDX_W-1:0]         hitIdx,
  output logic [IDX_W-1:0]         wrIdx,
  output logic [IDX_W-1:0]         touchIdx,
  output logic                     lkHit,
  output logic                     lkFault
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] dupIdx, freeIdx, lruIdx;
  logic             anyMatch, hitRo;

  // Lowest set bit wins in each encoder
  always_comb begin
    hitIdx  = '0;
    dupIdx  = '0;
    freeIdx = '0;
    lruIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i])     hitIdx  = IDX_W'(i);
      if (fillMatchVec[i]) dupIdx  = IDX_W'(i);
      if (!validVec[i])    freeIdx = IDX_W'(i);
      if (ageFlat[i*IDX_W +: IDX_W] == OLDEST) lruIdx = IDX_W'(i);
    end
  end

  assign anyMatch = lkValid && (|matchVec);
  assign hitRo    = roVec[hitIdx];
  assign lkFault  = anyMatch && lkWrite && hitRo;
  assign lkHit    = anyMatch && !(lkWrite && hitRo);

  always_comb begin
    if (|fillMatchVec)     wrIdx = dupIdx;
    else if (!(&validVec)) wrIdx = freeIdx;
    else                   wrIdx = lruIdx;
  end

  assign strb.clrAll  = flushAll;
  assign strb.clrAsid = !flushAll && flushAsidValid;
  assign strb.wrEn    = fillValid && !flushAll && !flushAsidValid;
  assign strb.touchEn = strb.wrEn || lkHit;
  assign touchIdx     = strb.wrEn ? wrIdx : hitIdx;
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int ASID_W  = 8,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lkValid,
  input  logic [VPN_W-1:0]       lkVpn,
  input  logic [ASID_W-1:0]      lkAsid,
  input  logic                   lkWrite,
  input  logic [OFF_W-1:0]       lkOffset,
  output logic                   lkHit,
  output logic                   lkFault,
  output logic [PFN_W-1:0]       lkPfn,
  output logic [PFN_W+OFF_W-1:0] lkPaddr,
  input  logic                   fillValid,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [ASID_W-1:0]      fillAsid,
  input  logic [PFN_W-1:0]       fillPfn,
  input  logic                   fillReadOnly,
  input  logic                   flushAll,
  input  logic                   flushAsidValid,
  input  logic [ASID_W-1:0]      flushAsid
);
  localparam int IDX_W = $clog2(ENTRIES);

  tlbStrobe_t               strb;
  logic [IDX_W-1:0]         hitIdx, wrIdx, touchIdx;
  logic [ENTRIES-1:0]       matchVec, fillMatchVec, validVec, roVec;
  logic [ENTRIES*IDX_W-1:0] ageFlat;
  logic [PFN_W-1:0]         rdPfn;

  asid_tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .touchIdx(touchIdx),
    .rdIdx(hitIdx), .fillVpn(fillVpn), .fillAsid(fillAsid), .fillPfn(fillPfn),
    .fillReadOnly(fillReadOnly), .flushAsid(flushAsid), .lkVpn(lkVpn),
    .lkAsid(lkAsid), .matchVec(matchVec), .fillMatchVec(fillMatchVec),
    .validVec(validVec), .roVec(roVec), .ageFlat(ageFlat), .rdPfn(rdPfn)
  );

  asid_tlb_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ctrl (
    .lkValid(lkValid), .lkWrite(lkWrite), .matchVec(matchVec),
    .fillMatchVec(fillMatchVec), .validVec(validVec), .roVec(roVec),
    .ageFlat(ageFlat), .fillValid(fillValid), .flushAll(flushAll),
    .flushAsidValid(flushAsidValid), .strb(strb), .hitIdx(hitIdx),
    .wrIdx(wrIdx), .touchIdx(touchIdx), .lkHit(lkHit), .lkFault(lkFault)
  );

  assign lkPfn   = lkHit ? rdPfn : '0;
  assign lkPaddr = lkHit ? {rdPfn, lkOffset} : '0;
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int ASID_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               lkValid,
  input logic               lkWrite,
  input logic [VPN_W-1:0]   lkVpn,
  input logic [ASID_W-1:0]  lkAsid,
  input logic               lkHit,
  input logic               lkFault,
  input logic [PFN_W-1:0]   lkPfn,
  input logic               fillValid,
  input logic [VPN_W-1:0]   fillVpn,
  input logic [ASID_W-1:0]  fillAsid,
  input logic [PFN_W-1:0]   fillPfn,
  input logic               flushAll,
  input logic               flushAsidValid,
  input logic [ENTRIES-1:0] validVec
);
  // R4
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(lkHit && lkFault));
  // R4
  fault_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkFault |-> (lkWrite && lkValid));
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> (!lkHit && !lkFault));
  // R9
  flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> (validVec == '0));
  // R10
  occupancy_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flushAll && !flushAsidValid) |=> ($countones(validVec) >= $countones($past(validVec))));
  // R5
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkWrite && $past(fillValid && !flushAll && !flushAsidValid)
     && lkVpn == $past(fillVpn) && lkAsid == $past(fillAsid))
    |-> (lkHit && lkPfn == $past(fillPfn)));
endmodule

bind asid_tlb asid_tlb_chk #(
  .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
) u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkWrite(lkWrite), .lkVpn(lkVpn),
  .lkAsid(lkAsid), .lkHit(lkHit), .lkFault(lkFault), .lkPfn(lkPfn),
  .fillValid(fillValid), .fillVpn(fillVpn), .fillAsid(fillAsid),
  .fillPfn(fillPfn), .flushAll(flushAll), .flushAsidValid(flushAsidValid),
  .validVec(validVec)
);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 16;
  localparam int VPN_W = 20, PFN_W = 16, ASID_W = 8, OFF_W = 12;

  logic clk = 0, rstN = 0;
  logic lkValid = 0, lkWrite = 0;
  logic [VPN_W-1:0] lkVpn = '0;
  logic [ASID_W-1:0] lkAsid = '0;
  logic [OFF_W-1:0] lkOffset = '0;
  logic lkHit, lkFault;
  logic [PFN_W-1:0] lkPfn;
  logic [PFN_W+OFF_W-1:0] lkPaddr;
  logic fillValid = 0, fillReadOnly = 0;
  logic [VPN_W-1:0] fillVpn = '0;
  logic [ASID_W-1:0] fillAsid = '0;
  logic [PFN_W-1:0] fillPfn = '0;
  logic flushAll = 0, flushAsidValid = 0;
  logic [ASID_W-1:0] flushAsid = '0;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W),
             .OFF_W(OFF_W)) u_dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic [PFN_W-1:0] p, input bit ro);
    @(negedge clk);
    fillValid = 1; fillVpn = v; fillAsid = a; fillPfn = p; fillReadOnly = ro;
    @(negedge clk);
    fillValid = 0;
  endtask

  // Drives a lookup at a falling edge, checks combinational outputs,
  // holds it through one rising edge (so a hit refreshes recency)
  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input bit wr, input bit expHit, input bit expFault,
                      input logic [PFN_W-1:0] expPfn, input string req);
    logic [PFN_W+OFF_W-1:0] expPa;
    @(negedge clk);
    lkValid = 1; lkVpn = v; lkAsid = a; lkWrite = wr; lkOffset = OFF_W'(v * 7 + 3);
    expPa = expHit ? {expPfn, lkOffset} : '0;
    #1;
    check(lkHit == expHit, {req, " hit"}, 64'(lkHit), 64'(expHit));
    check(lkFault == expFault, {req, " fault"}, 64'(lkFault), 64'(expFault));
    check(lkPfn == (expHit ? expPfn : '0), {req, " pfn"}, 64'(lkPfn),
          64'(expHit ? expPfn : '0));
    check(lkPaddr == expPa, {req, " paddr"}, 64'(lkPaddr), 64'(expPa));
    @(negedge clk);
    lkValid = 0; lkWrite = 0;
  endtask

  task automatic do_flush_all();
    @(negedge clk); flushAll = 1;
    @(negedge clk); flushAll = 0;
  endtask

  task automatic t_reset();  // R11
    look(20'h00000, 8'h00, 0, 0, 0, 0, "R11 reset");
    look(20'h00001, 8'h00, 1, 0, 0, 0, "R11 reset wr");
  endtask

  task automatic t_basic();  // R1 R5 R2 R3
    fill(20'h12345, 8'h07, 16'hBEEF, 0);
    look(20'h12345, 8'h07, 0, 1, 0, 16'hBEEF, "R5 R1 read hit");
    look(20'h12345, 8'h07, 1, 1, 0, 16'hBEEF, "R1 write hit rw");
    look(20'h12345, 8'h08, 0, 0, 0, 0, "R2 asid mismatch");
    look(20'h12346, 8'h07, 0, 0, 0, 0, "R3 vpn miss");
    @(negedge clk); lkValid = 0; lkVpn = 20'h12345; lkAsid = 8'h07; #1;
    check(!lkHit && !lkFault && lkPaddr == 0, "R3 idle", 64'(lkHit), 0);
  endtask

  task automatic t_readonly();  // R4
    fill(20'h00AAA, 8'h03, 16'h0123, 1);
    look(20'h00AAA, 8'h03, 0, 1, 0, 16'h0123, "R4 ro read");
    look(20'h00AAA, 8'h03, 1, 0, 1, 0, "R4 ro write");
    look(20'h00AAA, 8'h04, 1, 0, 0, 0, "R2 R4 ro other asid");
  endtask

  task automatic t_flush_all();  // R9
    do_flush_all();
    look(20'h12345, 8'h07, 0, 0, 0, 0, "R9 after flush");
    fill(20'h00055, 8'h01, 16'h0055, 0);
    @(negedge clk);
    flushAll = 1; fillValid = 1; fillVpn = 20'h00066; fillAsid = 8'h01; fillPfn = 16'h0066;
    @(negedge clk);
    flushAll = 0; fillValid = 0;
    look(20'h00066, 8'h01, 0, 0, 0, 0, "R9 fill dropped");
    look(20'h00055, 8'h01, 0, 0, 0, 0, "R9 old cleared");
  endtask

  task automatic t_asid_flush();  // R10 R7
    do_flush_all();
    for (int i = 0; i < ENTRIES; i++)
      fill(VPN_W'(20'h300 + i), (i < ENTRIES/2) ? 8'h03 : 8'h04, PFN_W'(16'h3000 + i), 0);
    @(negedge clk);
    flushAsidValid = 1; flushAsid = 8'h03;
    fillValid = 1; fillVpn = 20'h999; fillAsid = 8'h04; fillPfn = 16'h0999;
    @(negedge clk);
    flushAsidValid = 0; fillValid = 0;
    look(20'h999, 8'h04, 0, 0, 0, 0, "R10 fill dropped");
    look(20'h300, 8'h03, 0, 0, 0, 0, "R10 asid3 cleared");
    // Refill freed slots; no asid-4 entry may be evicted
    for (int i = 0; i < ENTRIES/2; i++)
      fill(VPN_W'(20'h500 + i), 8'h05, PFN_W'(16'h5000 + i), 0);
    for (int i = ENTRIES/2; i < ENTRIES; i++)
      look(VPN_W'(20'h300 + i), 8'h04, 0, 1, 0, PFN_W'(16'h3000 + i), "R7 R10 kept");
    look(20'h503, 8'h05, 0, 1, 0, 16'h5003, "R7 free slot used");
  endtask

  task automatic t_dup();  // R6
    do_flush_all();
    for (int i = 0; i < ENTRIES; i++)
      fill(VPN_W'(20'h700 + i), 8'h02, PFN_W'(16'h7000 + i), 0);
    fill(20'h700, 8'h02, 16'h7777, 1);
    look(20'h700, 8'h02, 0, 1, 0, 16'h7777, "R6 overwrite");
    look(20'h700, 8'h02, 1, 0, 1, 0, "R6 new ro flag");
    for (int i = 1; i < ENTRIES; i++)
      look(VPN_W'(20'h700 + i), 8'h02, 0, 1, 0, PFN_W'(16'h7000 + i), "R6 others kept");
  endtask

  task automatic t_lru();  // R8
    do_flush_all();
    for (int i = 0; i < ENTRIES; i++)
      fill(VPN_W'(20'h100 + i), 8'h09, PFN_W'(16'h1000 + i), 0);
    look(20'h100, 8'h09, 0, 1, 0, 16'h1000, "R8 refresh");
    fill(20'h200, 8'h09, 16'h2000, 0);
    look(20'h101, 8'h09, 0, 0, 0, 0, "R8 oldest evicted");
    look(20'h100, 8'h09, 0, 1, 0, 16'h1000, "R8 refreshed kept");
    look(20'h200, 8'h09, 0, 1, 0, 16'h2000, "R8 new present");
    fill(20'h201, 8'h09, 16'h2001, 0);
    look(20'h102, 8'h09, 0, 0, 0, 0, "R8 next oldest evicted");
    look(20'h103, 8'h09, 0, 1, 0, 16'h1003, "R8 younger kept");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_basic();
    t_readonly();
    t_flush_all();
    t_asid_flush();
    t_dup();
    t_lru();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule